// File: doc/BRIEF.md
# Bit-Serial Link DMA Channel

This block is the DMA engine behind one bit-serial link of a node processor. Software writes a start address and then a byte count. A nonzero count launches the transfer, and the processor carries on with its own work while the channel runs. For each byte, the channel requests a single cycle on the node memory bus and waits for the grant before it reads or writes.

A transmit instance reads each byte from memory and sends it on the line. A receive instance collects bytes from the line and writes them into memory. On the line, a byte is a frame of nine bit times qualified by a valid strobe: eight data bits with the least significant bit first, then one even-parity bit. The remaining byte count is visible at all times. When the last byte completes, the channel raises a level interrupt that signals it is ready for the next transfer.

Top module: `serial_link_dma`

## Requirements
- R1: After reset, `busy`, `irq`, `parity_err`, `mem_req` and `tx_vld` are 0 and `bytes_left` is 0.
- R2: While idle, a write with `cfg_sel`=0 loads the start address. A write with `cfg_sel`=1 and nonzero data loads the count and starts a transfer. From the next cycle, `busy` is 1 and `bytes_left` equals the written value.
- R3: While idle, a count write of zero starts nothing. `busy` and `mem_req` stay 0 and `irq` keeps its value.
- R4: Register writes of either kind that arrive while `busy` is 1 are ignored. The count and the address sequence are unaffected.
- R5: For each byte, `mem_req` is held with a stable `mem_addr` until `mem_grant` is seen. The access happens in the grant cycle, and read data is taken from `mem_rdata` in that same cycle.
- R6: The first access of a transfer uses the programmed start address. Each later access uses the previous address plus one, so a transfer makes exactly as many accesses as its count.
- R7: `bytes_left` drops by exactly one as each byte completes. A transmitted byte completes with its last bit time. A received byte completes with its memory write grant.
- R8: A transmit frame is 9 consecutive cycles with `tx_vld`=1. Bits 0..7 of the byte come first, then a parity bit chosen so that the frame holds an even number of ones.
- R9: A receive channel samples `rx_bit` on each cycle with `rx_vld`=1 while busy, assembles a frame, and writes the data byte to memory with `mem_we`=1.
- R10: A receive frame with an odd number of ones sets `parity_err`. The flag holds until the next nonzero count write clears it. The received byte is still stored.
- R11: `irq` rises when the last byte completes, with `bytes_left` at 0. It stays high until a nonzero count write clears it, and it is never 1 while `busy` is 1.
- R12: Parameter `IS_RX` fixes the direction. With 0, the channel only reads memory (`mem_we`=0). With 1, it only writes memory (`mem_we`=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the channel and the link |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects start address, 1 selects byte count |
| cfg_wdata | input | REG_W | Register write data |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | Ready interrupt level |
| parity_err | output | 1 | Sticky receive parity mismatch |
| bytes_left | output | REG_W | Bytes remaining in the transfer |
| mem_req | output | 1 | Memory bus request for one byte |
| mem_grant | input | 1 | Bus granted this cycle |
| mem_we | output | 1 | 1 for a memory write |
| mem_addr | output | REG_W | Byte address of the access |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the grant cycle |
| tx_vld | output | 1 | Transmit bit valid |
| tx_bit | output | 1 | Transmit serial data |
| rx_vld | input | 1 | Receive bit valid |
| rx_bit | input | 1 | Receive serial data |

## Verification
The embedded assertions cover the per-cycle rules:
- the request is held with a stable address until it is granted;
- a rising `busy` only follows a nonzero count write;
- the count falls by at most one per cycle;
- the address steps by one per grant;
- `irq` and `busy` are never both high;
- the serializer is never reloaded in the middle of a frame.

Other behaviour can only be shown by the bench, with a transmit channel looped into a receive channel across lengths and grant delays:
- the data bytes and parity produced on the line;
- the byte order in memory;
- sticky parity errors after a corrupted bit;
- writes that are ignored while busy;
- the zero-count case.

// File: rtl/sld_pkg.sv
package sld_pkg;
    localparam int DATA_W     = 8;
    localparam int FRAME_BITS = DATA_W + 1;
    localparam int BITCNT_W   = $clog2(FRAME_BITS);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MEM  = 2'd1,
        ST_LINK = 2'd2
    } chan_state_e;
endpackage

// File: rtl/sld_tx_ser.sv
module sld_tx_ser
    import sld_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    output logic              tx_vld,
    output logic              tx_bit,
    output logic              frame_done
);
    localparam logic [BITCNT_W-1:0] LAST_BIT = BITCNT_W'(FRAME_BITS - 1);

    typedef struct packed {
        logic                  active;
        logic [FRAME_BITS-1:0] shreg;
        logic [BITCNT_W-1:0]   cnt;
    } ser_s;

    ser_s r_q, r_d;

    always_comb begin
        r_d        = r_q;
        frame_done = 1'b0;
        if (load) begin
            r_d.active = 1'b1;
            r_d.shreg  = {^load_data, load_data};
            r_d.cnt    = '0;
        end else if (r_q.active) begin
            r_d.shreg = r_q.shreg >> 1;
            if (r_q.cnt == LAST_BIT) begin
                r_d.active = 1'b0;
                frame_done = 1'b1;
            end else begin
                r_d.cnt = r_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign tx_vld = r_q.active;
    assign tx_bit = r_q.shreg[0];

    assert_no_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !r_q.active);
endmodule

// File: rtl/sld_rx_des.sv
module sld_rx_des
    import sld_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              rx_vld,
    input  logic              rx_bit,
    output logic              frame_done,
    output logic [DATA_W-1:0] frame_data,
    output logic              frame_perr
);
    localparam logic [BITCNT_W-1:0] LAST_BIT = BITCNT_W'(FRAME_BITS - 1);

    typedef struct packed {
        logic [FRAME_BITS-1:0] shreg;
        logic [BITCNT_W-1:0]   cnt;
        logic                  done;
        logic                  perr;
    } des_s;

    des_s r_q, r_d;
    logic [FRAME_BITS-1:0] shifted;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.perr = 1'b0;
        shifted  = {rx_bit, r_q.shreg[FRAME_BITS-1:1]};
        if (!en) begin
            r_d.cnt = '0;
        end else if (rx_vld) begin
            r_d.shreg = shifted;
            if (r_q.cnt == LAST_BIT) begin
                r_d.cnt  = '0;
                r_d.done = 1'b1;
                r_d.perr = ^shifted;
            end else begin
                r_d.cnt = r_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign frame_done = r_q.done;
    assign frame_data = r_q.shreg[DATA_W-1:0];
    assign frame_perr = r_q.perr;

    assert_done_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.done |-> $past(en && rx_vld));
endmodule

// File: rtl/sld_ctrl.sv
module sld_ctrl
    import sld_pkg::*;
#(
    parameter int REG_W = 32,
    parameter bit IS_RX = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic              busy,
    output logic              irq,
    output logic              parity_err,
    output logic [REG_W-1:0]  bytes_left,
    output logic              mem_req,
    input  logic              mem_grant,
    output logic              mem_we,
    output logic [REG_W-1:0]  mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              ser_load,
    output logic [DATA_W-1:0] ser_data,
    output logic              link_en,
    input  logic              link_done,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_perr
);
    localparam logic [REG_W-1:0] ONE = REG_W'(1);

    typedef struct packed {
        chan_state_e       state;
        logic [REG_W-1:0]  addr;
        logic [REG_W-1:0]  count;
        logic [DATA_W-1:0] data;
        logic              irq;
        logic              perr;
    } ctrl_s;

    ctrl_s r_q, r_d;

    always_comb begin
        r_d      = r_q;
        ser_load = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (cfg_we) begin
                    if (!cfg_sel) begin
                        r_d.addr = cfg_wdata;
                    end else begin
                        r_d.count = cfg_wdata;
                        if (cfg_wdata != '0) begin
                            r_d.irq   = 1'b0;
                            r_d.perr  = 1'b0;
                            r_d.state = IS_RX ? ST_LINK : ST_MEM;
                        end
                    end
                end
            end
            ST_MEM: begin
                if (mem_grant) begin
                    r_d.addr = r_q.addr + ONE;
                    if (IS_RX) begin
                        r_d.count = r_q.count - ONE;
                        if (r_q.count == ONE) begin
                            r_d.state = ST_IDLE;
                            r_d.irq   = 1'b1;
                        end else begin
                            r_d.state = ST_LINK;
                        end
                    end else begin
                        ser_load  = 1'b1;
                        r_d.state = ST_LINK;
                    end
                end
            end
            ST_LINK: begin
                if (link_done) begin
                    if (IS_RX) begin
                        r_d.data  = rx_data;
                        r_d.perr  = r_q.perr | rx_perr;
                        r_d.state = ST_MEM;
                    end else begin
                        r_d.count = r_q.count - ONE;
                        if (r_q.count == ONE) begin
                            r_d.state = ST_IDLE;
                            r_d.irq   = 1'b1;
                        end else begin
                            r_d.state = ST_MEM;
                        end
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign busy       = (r_q.state != ST_IDLE);
    assign irq        = r_q.irq;
    assign parity_err = r_q.perr;
    assign bytes_left = r_q.count;
    assign mem_req    = (r_q.state == ST_MEM);
    assign mem_we     = IS_RX;
    assign mem_addr   = r_q.addr;
    assign mem_wdata  = r_q.data;
    assign ser_data   = mem_rdata;
    assign link_en    = busy;

    assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_grant |=> mem_req && $stable(mem_addr));
    assert_start_from_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cfg_we && cfg_sel && (cfg_wdata != '0)));
    assert_busy_irq_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && irq));
    assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (($past(bytes_left) - bytes_left) <= ONE));
    assert_irq_at_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (bytes_left == '0));
    assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_grant |=> mem_addr == $past(mem_addr) + ONE);
endmodule

// File: rtl/serial_link_dma.sv
module serial_link_dma
    import sld_pkg::*;
#(
    parameter int REG_W = 32,
    parameter bit IS_RX = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic              busy,
    output logic              irq,
    output logic              parity_err,
    output logic [REG_W-1:0]  bytes_left,
    output logic              mem_req,
    input  logic              mem_grant,
    output logic              mem_we,
    output logic [REG_W-1:0]  mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic              tx_vld,
    output logic              tx_bit,
    input  logic              rx_vld,
    input  logic              rx_bit
);
    logic              ser_load;
    logic [DATA_W-1:0] ser_data;
    logic              link_en;
    logic              link_done;
    logic [DATA_W-1:0] rx_data;
    logic              rx_perr;

    sld_ctrl #(.REG_W(REG_W), .IS_RX(IS_RX)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .busy       (busy),
        .irq        (irq),
        .parity_err (parity_err),
        .bytes_left (bytes_left),
        .mem_req    (mem_req),
        .mem_grant  (mem_grant),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .ser_load   (ser_load),
        .ser_data   (ser_data),
        .link_en    (link_en),
        .link_done  (link_done),
        .rx_data    (rx_data),
        .rx_perr    (rx_perr)
    );

    generate
        if (IS_RX) begin : g_rx
            logic unused_tx_side;
            assign unused_tx_side = ^{ser_load, ser_data};
            assign tx_vld = 1'b0;
            assign tx_bit = 1'b0;
            sld_rx_des u_des (
                .clk        (clk),
                .rst_n      (rst_n),
                .en         (link_en),
                .rx_vld     (rx_vld),
                .rx_bit     (rx_bit),
                .frame_done (link_done),
                .frame_data (rx_data),
                .frame_perr (rx_perr)
            );
        end else begin : g_tx
            logic unused_rx_side;
            assign unused_rx_side = ^{rx_vld, rx_bit, link_en};
            assign rx_data = '0;
            assign rx_perr = 1'b0;
            sld_tx_ser u_ser (
                .clk        (clk),
                .rst_n      (rst_n),
                .load       (ser_load),
                .load_data  (ser_data),
                .tx_vld     (tx_vld),
                .tx_bit     (tx_bit),
                .frame_done (link_done)
            );
        end
    endgenerate
endmodule

// File: tb/test_serial_link_dma.sv
`timescale 1ns/1ps
module test_serial_link_dma;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        t_we = 0, t_sel = 0, r_we = 0, r_sel = 0;
    logic [31:0] t_wd = 0, r_wd = 0;
    logic        t_busy, t_irq, t_perr, r_busy, r_irq, r_perr;
    logic [31:0] t_left, r_left, t_addr, r_addr;
    logic        t_req, r_req, t_memwe, r_memwe;
    logic        t_gnt = 0, r_gnt = 0;
    logic [7:0]  t_wdat, r_wdat, t_rdat;
    logic        t_vld, t_bit, r_txv, r_txb;
    logic        corrupt_now = 0;
    logic        link_bit;

    int n_chk = 0, n_fail = 0;
    int wait_cyc = 0;
    logic [7:0] rx_mem [256];

    function automatic logic [7:0] pat(input logic [31:0] a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    assign t_rdat   = pat(t_addr);
    assign link_bit = t_bit ^ corrupt_now;

    serial_link_dma #(.REG_W(32), .IS_RX(1'b0)) i_serial_link_dma (
        .clk(clk), .rst_n(rst_n), .cfg_we(t_we), .cfg_sel(t_sel), .cfg_wdata(t_wd),
        .busy(t_busy), .irq(t_irq), .parity_err(t_perr), .bytes_left(t_left),
        .mem_req(t_req), .mem_grant(t_gnt), .mem_we(t_memwe), .mem_addr(t_addr),
        .mem_wdata(t_wdat), .mem_rdata(t_rdat), .tx_vld(t_vld), .tx_bit(t_bit),
        .rx_vld(1'b0), .rx_bit(1'b0));

    serial_link_dma #(.REG_W(32), .IS_RX(1'b1)) i_serial_link_dma_rx (
        .clk(clk), .rst_n(rst_n), .cfg_we(r_we), .cfg_sel(r_sel), .cfg_wdata(r_wd),
        .busy(r_busy), .irq(r_irq), .parity_err(r_perr), .bytes_left(r_left),
        .mem_req(r_req), .mem_grant(r_gnt), .mem_we(r_memwe), .mem_addr(r_addr),
        .mem_wdata(r_wdat), .mem_rdata(8'h00), .tx_vld(r_txv), .tx_bit(r_txb),
        .rx_vld(t_vld), .rx_bit(link_bit));

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor state
    int t_len = 0, r_len = 0, t_frames = 0, r_done = 0, t_grants = 0;
    logic [31:0] t_exp_addr = 0, r_exp_addr = 0, t_base = 0;
    int t_w = 0, r_w = 0, bitk = 0;
    logic [8:0] frame;
    bit t_pend = 0, flip_arm = 0;

    // transmit side: grants, address order, frame contents
    always @(negedge clk) begin
        if (t_pend) begin
            t_pend = 0;
            chk(t_left == 32'(t_len - t_frames), "R7 tx bytes_left", t_left, t_len - t_frames);
        end
        if (t_gnt) t_gnt = 0;
        else if (t_req) begin
            if (t_w >= wait_cyc) begin
                t_gnt = 1; t_w = 0;
                chk(t_addr == t_exp_addr, "R6 tx address", t_addr, t_exp_addr);
                chk(t_memwe == 1'b0, "R12 tx reads only", t_memwe, 0);
                t_exp_addr++; t_grants++;
            end else t_w++;
        end
        corrupt_now = 0;
        if (t_vld) begin
            if (bitk == 0 && flip_arm) begin corrupt_now = 1; flip_arm = 0; end
            frame[bitk] = t_bit;
            bitk++;
            if (bitk == 9) begin
                bitk = 0;
                chk(frame[7:0] == pat(t_base + 32'(t_frames)), "R8 frame data",
                    frame[7:0], pat(t_base + 32'(t_frames)));
                chk(($countones(frame) % 2) == 0, "R8 even parity", $countones(frame), 0);
                t_frames++;
                t_pend = 1;
            end
        end
    end

    // receive side: grants, address order, remaining count
    always @(negedge clk) begin
        if (r_gnt) begin
            r_gnt = 0;
            chk(r_left == 32'(r_len - r_done), "R7 rx bytes_left", r_left, r_len - r_done);
        end else if (r_req) begin
            if (r_w >= wait_cyc) begin
                r_gnt = 1; r_w = 0;
                chk(r_addr == r_exp_addr, "R6 rx address", r_addr, r_exp_addr);
                chk(r_memwe == 1'b1, "R12 rx writes only", r_memwe, 1);
                r_exp_addr++; r_done++;
            end else r_w++;
        end
    end

    always @(posedge clk) if (r_req && r_gnt && r_memwe) rx_mem[r_addr[7:0]] <= r_wdat;

    task automatic wr_t(input logic sel, input logic [31:0] d);
        @(negedge clk); t_we = 1; t_sel = sel; t_wd = d;
        @(negedge clk); t_we = 0;
    endtask

    task automatic wr_r(input logic sel, input logic [31:0] d);
        @(negedge clk); r_we = 1; r_sel = sel; r_wd = d;
        @(negedge clk); r_we = 0;
    endtask

    task automatic run_xfer(input int len, input logic [31:0] tb_, input logic [31:0] rb,
                            input int wt, input bit flip, input bit poke);
        wait_cyc = wt;
        t_len = len; r_len = len; t_frames = 0; r_done = 0; t_grants = 0;
        t_exp_addr = tb_; r_exp_addr = rb; t_base = tb_; flip_arm = flip;
        wr_r(1'b0, rb);
        wr_r(1'b1, 32'(len));
        chk(r_busy == 1'b1, "R2 rx start", r_busy, 1);
        chk(r_perr == 1'b0, "R10 perr cleared by start", r_perr, 0);
        wr_t(1'b0, tb_);
        wr_t(1'b1, 32'(len));
        chk(t_busy == 1'b1, "R2 tx start", t_busy, 1);
        chk(t_irq == 1'b0, "R11 irq cleared on start", t_irq, 0);
        if (poke) begin
            wr_t(1'b1, 32'd200);
            wr_t(1'b0, 32'd9999);
            chk(t_left <= 32'(len), "R4 busy write ignored", t_left, len);
        end
        for (int i = 0; i < 3000 && !(t_irq && r_irq); i++) @(negedge clk);
        @(negedge clk);
        chk(t_irq && r_irq, "R11 irq on completion", {t_irq, r_irq}, 3);
        chk(!t_busy && !r_busy, "R11 idle at end", {t_busy, r_busy}, 0);
        chk(t_left == 0 && r_left == 0, "R7 count reaches zero", t_left + r_left, 0);
        chk(t_grants == len, "R6 tx access count", t_grants, len);
        chk(r_done == len, "R9 rx access count", r_done, len);
        for (int i = 0; i < len; i++) begin
            logic [7:0] e;
            e = pat(tb_ + 32'(i)) ^ ((flip && i == 0) ? 8'h01 : 8'h00);
            chk(rx_mem[8'(rb + 32'(i))] == e, "R9 rx data", rx_mem[8'(rb + 32'(i))], e);
        end
        chk(r_perr == flip, "R10 parity flag", r_perr, flip);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!t_busy && !t_irq && !t_perr && !t_req && !t_vld && t_left == 0,
            "R1 tx reset", {t_busy, t_irq, t_perr, t_req, t_vld}, 0);
        chk(!r_busy && !r_irq && !r_perr && !r_req && r_left == 0,
            "R1 rx reset", {r_busy, r_irq, r_perr, r_req}, 0);
        rst_n = 1;
        @(negedge clk);
        // zero count before any transfer
        wr_t(1'b1, 32'd0);
        repeat (3) @(negedge clk);
        chk(!t_busy && !t_req && !t_irq, "R3 zero count idle", {t_busy, t_req, t_irq}, 0);
        for (int len = 1; len <= 8; len++)
            for (int wt = 0; wt <= 2; wt++)
                run_xfer(len, 32'(len * 16 + wt * 3), 32'(len * 20 + wt),
                         wt, (len == 3 && wt == 1), (len >= 4));
        // zero count after completion leaves irq asserted
        wr_t(1'b1, 32'd0);
        repeat (3) @(negedge clk);
        chk(!t_busy && !t_req && t_irq, "R3 zero count keeps irq", {t_busy, t_req, t_irq}, 1);
        chk(t_left == 0, "R3 zero count loaded", t_left, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule